// File: doc/BRIEF.md
# Bus Control Slice with Timeout Interrupt

This block is the control and status slice of a shared-bus arbiter. It holds a small control register that software reaches through a simple register port. The register has three fields: an interrupt enable, a self-clearing bus reset, and a test enable. The block also runs a watchdog on the address phase of each transfer. If an address stays valid for too long with no slave acknowledge, the watchdog raises a one-cycle error interrupt and records the address of the transfer that failed.

The captured address is locked after the first timeout, so later timeouts do not overwrite it. Software releases the lock explicitly. When the test enable is set, software can also write the captured address directly. Separately, the block merges the interrupt requests that slaves direct at masters into one request line per master. The block can be built without the register port. In that build, interrupts are always enabled.

Top module: `bus_ctl_slice`

## Requirements
- R1: After reset, the control register reads 1 in bit 0 and 0 in all other bits. The irq output sits at its inactive level. bus_rst and mst_irq are 0. The error address (select 1) and the status (select 2) read 0.
- R2: Control bit 0 (select 0) is the interrupt enable. It is read/write. Control bits 3 and above always read as zero.
- R3: Writing control bit 1 as 1 drives bus_rst high for the one cycle that follows the write. Control bit 1 always reads 0.
- R4: The bus_rst pulse clears the watchdog count, the capture lock and the captured address. The interrupt-enable and test-enable values keep what was last written.
- R5: A timeout occurs on the TIMEOUT_CYC-th consecutive clock edge at which addr_valid is high and slv_ack is low. Either an acknowledge or addr_valid going low restarts the count.
- R6: The irq output is active for exactly one cycle, starting at the edge where the timeout occurs. Its active level is high when IRQ_HIGH=1 and low when IRQ_HIGH=0.
- R7: While control bit 0 is 0, a timeout leaves irq inactive.
- R8: The first timeout while unlocked captures bus_addr into the error address and sets status bit 0 (the lock). While the lock is set, further timeouts keep the captured address but still raise irq.
- R9: Writing status (select 2) with bit 0 set clears the lock.
- R10: Control bit 2 is the test enable, read/write, reset 0. While it is 1, a write to select 1 replaces the error address. While it is 0, such a write is ignored.
- R11: One cycle after the inputs, mst_irq[m] equals the OR over all slaves s of sl_mirq[s*NUM_MST+m].
- R12: With HAS_REGPORT=0, register writes have no effect and every timeout raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 error address, 2 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for reg_sel |
| addr_valid | input | 1 | Bus address valid |
| slv_ack | input | 1 | Any-slave address acknowledge |
| bus_addr | input | ADDR_W | Current bus address |
| sl_mirq | input | NUM_SLV*NUM_MST | Slave-to-master requests, bit s*NUM_MST+m |
| irq | output | 1 | One-cycle timeout interrupt, polarity set by IRQ_HIGH |
| bus_rst | output | 1 | One-cycle bus reset pulse |
| mst_irq | output | NUM_MST | Merged request per master |

## Verification
The bench checks the watchdog at its exact edge. One cycle too early or too late shows up as an irq at the wrong sample. A count that fails to restart after an acknowledge shows up as a timeout that should not happen. It runs a second timeout while the lock is held. A design that overwrites the captured address would read back the wrong value here, and a design that suppresses irq while locked would miss the pulse. The bench sweeps every test-enable and reset-pulse combination against readback. A bit 1 that sticks, or a reset that wipes the enables, would show on read. It also sweeps all 4096 request vectors, which catches an OR formed over the wrong index.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam int CB_IE  = 0;
  localparam int CB_RST = 1;
  localparam int CB_TE  = 2;
endpackage

// File: rtl/bcs_timeout.sv
module bcs_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic valid,
  input  logic ack,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (!valid || ack)  cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign hit = valid && !ack && !clr && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R5
  AST_ACK_RESTART: assert property (@(posedge clk) disable iff (rst)
    ack |=> cnt == '0); // R5
endmodule

// File: rtl/bcs_errcap.sv
module bcs_errcap #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              tw_en,
  input  logic [ADDR_W-1:0] tw_data,
  input  logic              unlock,
  output logic [ADDR_W-1:0] err_addr,
  output logic              locked
);
  logic take;
  assign take = hit && !locked;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_addr <= '0;
      locked   <= 1'b0;
    end else begin
      if (take)        err_addr <= bus_addr;
      else if (tw_en)  err_addr <= tw_data;
      if (take)        locked <= 1'b1;
      else if (unlock) locked <= 1'b0;
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked && !tw_en && !clr) |=> $stable(err_addr)); // R8
  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!locked && err_addr == '0)); // R4
endmodule

// File: rtl/bcs_mirq_or.sv
module bcs_mirq_or #(
  parameter int NUM_MST = 4,
  parameter int NUM_SLV = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLV*NUM_MST-1:0] req,
  output logic [NUM_MST-1:0]         merged
);
  logic [NUM_MST-1:0] any;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic [NUM_SLV-1:0] col;
    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
      assign col[s] = req[s*NUM_MST + m];
    end
    assign any[m] = |col;
  end

  always_ff @(posedge clk) begin
    if (rst) merged <= '0;
    else     merged <= any;
  end

  AST_MIRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (merged == '0)); // R11
endmodule

// File: rtl/bus_ctl_slice.sv
module bus_ctl_slice #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int NUM_MST     = 4,
  parameter int NUM_SLV     = 3,
  parameter int TIMEOUT_CYC = 16,
  parameter bit IRQ_HIGH    = 1'b1,
  parameter bit HAS_REGPORT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [1:0]                 reg_sel,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic                       addr_valid,
  input  logic                       slv_ack,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [NUM_SLV*NUM_MST-1:0] sl_mirq,
  output logic                       irq,
  output logic                       bus_rst,
  output logic [NUM_MST-1:0]         mst_irq
);
  import bcs_pkg::*;

  localparam logic IRQ_ON  = IRQ_HIGH;
  localparam logic IRQ_OFF = !IRQ_HIGH;

  logic              we_eff, wr_ctrl, ie, te, hit, locked;
  logic [ADDR_W-1:0] err_addr;

  assign we_eff  = HAS_REGPORT && reg_we;
  assign wr_ctrl = we_eff && (reg_sel == SEL_CTRL);

  if (HAS_REGPORT) begin : g_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        ie      <= 1'b1;
        te      <= 1'b0;
        bus_rst <= 1'b0;
      end else begin
        bus_rst <= wr_ctrl && reg_wdata[CB_RST];
        if (wr_ctrl) begin
          ie <= reg_wdata[CB_IE];
          te <= reg_wdata[CB_TE];
        end
      end
    end
  end else begin : g_noregs
    assign ie      = 1'b1;
    assign te      = 1'b0;
    assign bus_rst = 1'b0;
  end

  bcs_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst), .clr(bus_rst),
    .valid(addr_valid), .ack(slv_ack), .hit(hit)
  );

  bcs_errcap #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .clr(bus_rst), .hit(hit), .bus_addr(bus_addr),
    .tw_en(we_eff && te && (reg_sel == SEL_ADDR)),
    .tw_data(reg_wdata[ADDR_W-1:0]),
    .unlock(we_eff && (reg_sel == SEL_STAT) && reg_wdata[0]),
    .err_addr(err_addr), .locked(locked)
  );

  bcs_mirq_or #(.NUM_MST(NUM_MST), .NUM_SLV(NUM_SLV)) u_or (
    .clk(clk), .rst(rst), .req(sl_mirq), .merged(mst_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             irq <= IRQ_OFF;
    else if (hit && ie)  irq <= IRQ_ON;
    else                 irq <= IRQ_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_sel)
        SEL_CTRL: reg_rdata <= DATA_W'({te, 1'b0, ie});
        SEL_ADDR: reg_rdata <= DATA_W'(err_addr);
        SEL_STAT: reg_rdata <= DATA_W'(locked);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (irq == IRQ_ON) |=> (irq == IRQ_OFF)); // R6
  AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst) |-> $past(wr_ctrl && reg_wdata[CB_RST])); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ie |=> (irq == IRQ_OFF)); // R7
endmodule

// File: tb/sim_bus_ctl_slice.sv
module sim_bus_ctl_slice;
  localparam int DW = 32, AW = 32, NM = 4, NS = 3, TC = 16;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [DW-1:0] reg_wdata = 0, rd0, rd1;
  logic addr_valid = 0, slv_ack = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [NS*NM-1:0] sl_mirq = 0;
  logic irq0, irq1, brst0, brst1;
  logic [NM-1:0] mi0, mi1;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  bus_ctl_slice #(.DATA_W(DW), .ADDR_W(AW), .NUM_MST(NM), .NUM_SLV(NS),
    .TIMEOUT_CYC(TC), .IRQ_HIGH(1'b1), .HAS_REGPORT(1'b1)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .addr_valid(addr_valid),
    .slv_ack(slv_ack), .bus_addr(bus_addr), .sl_mirq(sl_mirq),
    .irq(irq0), .bus_rst(brst0), .mst_irq(mi0));

  bus_ctl_slice #(.DATA_W(DW), .ADDR_W(AW), .NUM_MST(NM), .NUM_SLV(NS),
    .TIMEOUT_CYC(TC), .IRQ_HIGH(1'b0), .HAS_REGPORT(1'b0)) u1 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rd1), .addr_valid(addr_valid),
    .slv_ack(slv_ack), .bus_addr(bus_addr), .sl_mirq(sl_mirq),
    .irq(irq1), .bus_rst(brst1), .mst_irq(mi1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); d = rd0;
  endtask

  // Hold addr_valid for TC edges; irq expected active after the TC-th edge.
  task automatic timeout(input logic [AW-1:0] a, input logic exp0, input string req);
    @(negedge clk); addr_valid = 1; bus_addr = a;
    repeat (TC - 1) @(negedge clk);
    chk({req, " early"}, {irq0, irq1}, 2'b01);
    @(negedge clk);
    chk({req, " pulse"}, {irq0, irq1}, {exp0, 1'b0});
    addr_valid = 0;
    @(negedge clk);
    chk({req, " self-clear"}, {irq0, irq1}, 2'b01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 1);
    rd(2'd1, d); chk("R1 addr", d, 0);
    rd(2'd2, d); chk("R1 stat", d, 0);
    chk("R1 outputs", {irq0, irq1, brst0, mi0}, {1'b0, 1'b1, 1'b0, 4'h0});

    // R2 / R10 field sweep, R3 bit1 reads 0, upper bits zero
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, DW'(v) | 32'hFFFF_FFF8 & 32'hFFFF_FFF8 & ~32'h2 | (v & 2));
      rd(2'd0, d);
      chk("R2 R3 ctrl readback", d, v & 5);
    end
    // R3 pulse timing
    @(negedge clk); reg_we = 1; reg_sel = 0; reg_wdata = 32'h7;
    chk("R3 before", brst0, 0);
    @(negedge clk); reg_we = 0;
    chk("R3 pulse", brst0, 1);
    chk("R12 no pulse", brst1, 0);
    @(negedge clk); chk("R3 one cycle", brst0, 0);
    rd(2'd0, d); chk("R4 settings kept", d, 5);

    // R10 test write while enabled
    wr(2'd1, 32'hCAFE_0001); rd(2'd1, d); chk("R10 te=1 write", d, 32'hCAFE_0001);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h1234_5678); rd(2'd1, d); chk("R10 te=0 ignored", d, 32'hCAFE_0001);
    wr(2'd2, 1); // R9 clear lock (not set yet)

    // R5 ack restarts count
    @(negedge clk); addr_valid = 1; bus_addr = 32'h10;
    repeat (TC - 1) @(negedge clk);
    slv_ack = 1; @(negedge clk); slv_ack = 0;
    repeat (TC - 1) @(negedge clk);
    chk("R5 ack restart", {irq0, irq1}, 2'b01);
    addr_valid = 0; @(negedge clk);
    chk("R5 drop restart", {irq0, irq1}, 2'b01);
    wr(2'd1, 32'h0); // te=0 here, ignored

    // R6 R8 first timeout captures
    timeout(32'hA5A5_0000, 1'b1, "R6");
    rd(2'd1, d); chk("R8 capture", d, 32'hA5A5_0000);
    rd(2'd2, d); chk("R8 lock", d, 1);
    timeout(32'h5A5A_1111, 1'b1, "R8 locked irq");
    rd(2'd1, d); chk("R8 hold", d, 32'hA5A5_0000);
    // R9 unlock then recapture
    wr(2'd2, 1); rd(2'd2, d); chk("R9 unlock", d, 0);
    timeout(32'h0BAD_F00D, 1'b1, "R9 recapture irq");
    rd(2'd1, d); chk("R9 recapture", d, 32'h0BAD_F00D);
    // R7 masked, R12 other instance still fires
    wr(2'd0, 32'h0);
    timeout(32'h1, 1'b0, "R7 R12");
    // R4 reset pulse clears capture, keeps te
    wr(2'd0, 32'h6);
    rd(2'd1, d); chk("R4 addr cleared", d, 0);
    rd(2'd2, d); chk("R4 lock cleared", d, 0);
    rd(2'd0, d); chk("R4 te kept", d, 4);
    wr(2'd0, 32'h1);

    // R11 exhaustive sweep
    for (int v = 0; v < (1 << (NS*NM)); v++) begin
      logic [NM-1:0] e;
      @(negedge clk); sl_mirq = (NS*NM)'(v);
      e = '0;
      for (int s = 0; s < NS; s++)
        for (int m = 0; m < NM; m++)
          if ((v >> (s*NM + m)) & 1) e[m] = 1'b1;
      @(negedge clk);
      chk("R11 merge", {mi0, mi1}, {e, e});
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule